// File: doc/BRIEF.md
# Slack-Guided Subgraph Grower

This engine partitions a buffered frame of up to 16 micro-ops into subgraphs that an accelerator array can run as one operation. Each op in the frame has an operation class, two source operands, a slack value and a live-out flag. A source operand either names an earlier op of the frame as its producer or names an external register. Frame entries are written through a simple write port. A start pulse, together with the number of valid ops, begins a run.

Seeds are taken from the last op of the frame back to the first. From each seed the engine grows a match toward producer ops. The most critical producer, the one with the lowest slack, is absorbed first. A candidate that breaks a constraint is dropped, and its producers are never reached through it. Matches that hold at least two ops are kept and numbered in the order they are found. When the run ends, the engine reports a match number for every op and a valid flag for every match number.

Top module: `sg_grower`

## Requirements
- R1: After start, seeds are tried from op n_ops-1 down to op 0, and an op already in a kept match is never used as a seed. At the end of a run, done is high for exactly one cycle while busy is low.
- R2: Among pending candidates, the one with the lowest slack is popped first. When two candidates have equal slack, the one with the higher op index is popped first.
- R3: An op whose class is 4 (memory), 5 (multiply), 6 or 7 is never added to a match, and its producers are not enqueued through it. Classes 0 to 3 are legal.
- R4: A match has at most 4 distinct inputs. An input is a producer op outside the match, or a distinct external register number, read by a member.
- R5: A match has at most 2 outputs. An output is a member that is flagged live-out, or that is read by an op of the frame outside the match.
- R6: No member may read a value that depends, through ops outside the match, on another member.
- R7: A grown match is kept only when it holds at least 2 ops. Kept matches get numbers 0, 1, 2 and so on in the order they are found, and match_ok bit k is set for each number k used. Ops in no match report number 15.
- R8: Ops at an index of n_ops or above take no part in the run and report number 15.
- R9: After reset, busy and done are low, match_ok is zero and every op reports number 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one frame entry |
| wr_idx | input | 4 | Entry index written |
| wr_cls | input | 3 | Operation class |
| wr_src_v | input | 2 | Per source: operand present |
| wr_src_x | input | 2 | Per source: operand is an external register |
| wr_src_i | input | 8 | Per source (4 bits each, source 0 low): producer index or register number |
| wr_slack | input | 4 | Slack of the op |
| wr_live | input | 1 | Result is live after the frame |
| start | input | 1 | Begin a run (ignored while busy) |
| n_ops | input | 5 | Number of valid ops, 0 to 16 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| match_id | output | 64 | 4-bit match number per op, op 0 lowest |
| match_ok | output | 8 | Valid flag per match number |

## Verification
The main function is tried on several kinds of frame. A plain dependent chain should collapse into one match. Two independent chains show seed order and numbering. A pair of producers that cannot both join is run with their slacks swapped and then made equal, which shows the pop order and the tie rule. Other frames are built so that exactly one constraint decides the result: a memory op in the middle of a chain, a path that leaves the match and comes back in, a fifth input, and a shared register that keeps the count at four. Each of these gives a different partition when the constraint under test is missing.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    CL_ARITH  = 3'd0,
    CL_LOGIC  = 3'd1,
    CL_MOVE   = 3'd2,
    CL_CMP    = 3'd3,
    CL_MEM    = 3'd4,
    CL_MUL    = 3'd5,
    CL_BRANCH = 3'd6,
    CL_RSVD   = 3'd7
  } op_class_e;

  function automatic logic class_legal(input logic [2:0] c);
    return c < 3'd4;
  endfunction
endpackage

// File: rtl/sg_pick.sv
module sg_pick #(
  parameter int N  = 16,
  parameter int SW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         queue,
  input  logic [N-1:0][SW-1:0] slack,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  logic [SW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int k = 0; k < N; k++) begin
      if (queue[k] && (!found || slack[k] <= best)) begin
        found = 1'b1;
        idx   = IW'(k);
        best  = slack[k];
      end
    end
  end
endmodule

// File: rtl/sg_check.sv
module sg_check #(
  parameter int N      = 16,
  parameter int MAXIN  = 4,
  parameter int MAXOUT = 2,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]                trial,
  input  logic [N-1:0]                in_frame,
  input  logic [N-1:0][1:0]           src_v,
  input  logic [N-1:0][1:0]           src_x,
  input  logic [N-1:0][1:0][IW-1:0]   src_i,
  input  logic [N-1:0]                live,
  output logic                        ok
);
  logic [N-1:0] prod, regs, consumed, outm, taint;
  logic         cyclic, feed;

  always_comb begin
    prod     = '0;
    regs     = '0;
    consumed = '0;
    for (int k = 0; k < N; k++) begin
      for (int s = 0; s < 2; s++) begin
        if (src_v[k][s]) begin
          if (trial[k]) begin
            if (src_x[k][s]) regs[src_i[k][s]] = 1'b1;
            else if (!trial[src_i[k][s]]) prod[src_i[k][s]] = 1'b1;
          end else if (in_frame[k] && !src_x[k][s]) begin
            consumed[src_i[k][s]] = 1'b1;
          end
        end
      end
    end
    outm = trial & (live | consumed);
  end

  always_comb begin
    taint  = '0;
    cyclic = 1'b0;
    for (int k = 0; k < N; k++) begin
      feed = 1'b0;
      for (int s = 0; s < 2; s++) begin
        if (src_v[k][s] && !src_x[k][s]) begin
          if (trial[src_i[k][s]] || taint[src_i[k][s]]) feed = 1'b1;
          if (trial[k] && taint[src_i[k][s]]) cyclic = 1'b1;
        end
      end
      if (!trial[k] && in_frame[k] && feed) taint[k] = 1'b1;
    end
  end

  assign ok = ($countones(prod) + $countones(regs) <= MAXIN) &&
              ($countones(outm) <= MAXOUT) && !cyclic;
endmodule

// File: rtl/sg_grower.sv
module sg_grower #(
  parameter int N      = 16,
  parameter int SW     = 4,
  parameter int MAXIN  = 4,
  parameter int MAXOUT = 2,
  parameter int MINOPS = 2,
  localparam int IW  = $clog2(N),
  localparam int CW  = $clog2(N + 1),
  localparam int MW  = N / 2,
  localparam int MIW = $clog2(MW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [2:0]      wr_cls,
  input  logic [1:0]      wr_src_v,
  input  logic [1:0]      wr_src_x,
  input  logic [2*IW-1:0] wr_src_i,
  input  logic [SW-1:0]   wr_slack,
  input  logic            wr_live,
  input  logic            start,
  input  logic [CW-1:0]   n_ops,
  output logic            busy,
  output logic            done,
  output logic [N*IW-1:0] match_id,
  output logic [MW-1:0]   match_ok
);
  import sg_pkg::*;

  typedef enum logic [2:0] {S_IDLE, S_SEED, S_GROW, S_CLOSE, S_FIN} st_e;

  // frame storage: one write port, parallel read by the constraint logic
  logic [N-1:0][2:0]          f_cls;
  logic [N-1:0][1:0]          f_v, f_x;
  logic [N-1:0][1:0][IW-1:0]  f_i;
  logic [N-1:0][SW-1:0]       f_slk;
  logic [N-1:0]               f_live;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      f_cls[wr_idx]  <= wr_cls;
      f_v[wr_idx]    <= wr_src_v;
      f_x[wr_idx]    <= wr_src_x;
      f_i[wr_idx]    <= wr_src_i;
      f_slk[wr_idx]  <= wr_slack;
      f_live[wr_idx] <= wr_live;
    end
  end

  st_e                  st;
  logic [CW-1:0]        n_r;
  logic [IW-1:0]        seed;
  logic [N-1:0]         cur, queue, tried, matched;
  logic [MIW-1:0]       next_id;
  logic [N-1:0][IW-1:0] ids;

  logic [N-1:0] in_frame, cand_oh, trial, parents, illegal;
  logic         pk_found, chk_ok, accept;
  logic [IW-1:0] pk_idx;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      in_frame[k] = CW'(k) < n_r;
      illegal[k]  = !class_legal(f_cls[k]);
    end
  end

  sg_pick #(.N(N), .SW(SW)) u_pick (
    .queue(queue), .slack(f_slk), .found(pk_found), .idx(pk_idx)
  );

  assign cand_oh = pk_found ? (N'(1) << pk_idx) : '0;
  assign trial   = cur | cand_oh;

  sg_check #(.N(N), .MAXIN(MAXIN), .MAXOUT(MAXOUT)) u_check (
    .trial(trial), .in_frame(in_frame), .src_v(f_v), .src_x(f_x),
    .src_i(f_i), .live(f_live), .ok(chk_ok)
  );

  always_comb begin
    parents = '0;
    for (int s = 0; s < 2; s++)
      if (f_v[pk_idx][s] && !f_x[pk_idx][s]) parents[f_i[pk_idx][s]] = 1'b1;
  end

  assign accept = pk_found && !illegal[pk_idx] && chk_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      n_r      <= '0;
      seed     <= '0;
      cur      <= '0;
      queue    <= '0;
      tried    <= '0;
      matched  <= '0;
      next_id  <= '0;
      ids      <= '1;
      match_ok <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy     <= 1'b1;
          n_r      <= n_ops;
          seed     <= IW'(n_ops - CW'(1));
          matched  <= '0;
          next_id  <= '0;
          ids      <= '1;
          match_ok <= '0;
          st       <= (n_ops == '0) ? S_FIN : S_SEED;
        end
        S_SEED: begin
          if (matched[seed]) begin
            if (seed == '0) st <= S_FIN;
            else seed <= seed - IW'(1);
          end else begin
            cur   <= '0;
            tried <= '0;
            queue <= N'(1) << seed;
            st    <= S_GROW;
          end
        end
        S_GROW: begin
          if (!pk_found) begin
            st <= S_CLOSE;
          end else begin
            tried <= tried | cand_oh;
            if (accept) begin
              cur   <= trial;
              queue <= (queue & ~cand_oh) |
                       (parents & in_frame & ~matched & ~trial & ~tried);
            end else begin
              queue <= queue & ~cand_oh;
            end
          end
        end
        S_CLOSE: begin
          if ($countones(cur) >= MINOPS) begin
            for (int j = 0; j < N; j++)
              if (cur[j]) ids[j] <= IW'(next_id);
            match_ok[next_id] <= 1'b1;
            matched <= matched | cur;
            next_id <= next_id + MIW'(1);
          end
          cur <= '0;
          if (seed == '0) st <= S_FIN;
          else begin
            seed <= seed - IW'(1);
            st   <= S_SEED;
          end
        end
        S_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign match_id = ids;

  // R1: end-of-run pulse lasts one cycle and comes with busy low
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R2: the popped candidate is always one that is pending
  a_r2_pick_pending: assert property (@(posedge clk) disable iff (rst)
    (st == S_GROW && pk_found) |-> queue[pk_idx]);
  // R3: no illegal class ever sits in the growing match
  a_r3_members_legal: assert property (@(posedge clk) disable iff (rst)
    (cur & illegal) == '0);
  // R8: the match never reaches past the frame length
  a_r8_within_frame: assert property (@(posedge clk) disable iff (rst)
    (cur & ~in_frame) == '0);
  // R7: a match below the size limit leaves the valid flags untouched
  a_r7_single_dropped: assert property (@(posedge clk) disable iff (rst)
    (st == S_CLOSE && $countones(cur) < MINOPS) |=> match_ok == $past(match_ok));
endmodule

// File: tb/tb_sg_grower.sv
module tb_sg_grower;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [IW-1:0] wr_idx;
  logic [2:0] wr_cls;
  logic [1:0] wr_src_v, wr_src_x;
  logic [2*IW-1:0] wr_src_i;
  logic [3:0] wr_slack;
  logic wr_live, start;
  logic [4:0] n_ops;
  logic busy, done;
  logic [N*IW-1:0] match_id;
  logic [7:0] match_ok;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  sg_grower dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cls(wr_cls),
    .wr_src_v(wr_src_v), .wr_src_x(wr_src_x), .wr_src_i(wr_src_i),
    .wr_slack(wr_slack), .wr_live(wr_live), .start(start), .n_ops(n_ops),
    .busy(busy), .done(done), .match_id(match_id), .match_ok(match_ok)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // op: class, src0 (present, external, index), src1, slack, live-out
  task automatic put(input int i, input int c, input bit v0, input bit x0, input int i0,
                     input bit v1, input bit x1, input int i1, input int slk, input bit lv);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(i); wr_cls = 3'(c);
    wr_src_v = {v1, v0}; wr_src_x = {x1, x0};
    wr_src_i = {IW'(i1), IW'(i0)}; wr_slack = 4'(slk); wr_live = lv;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n, input string tag);
    int cyc = 0;
    @(negedge clk);
    start = 1; n_ops = 5'(n);
    @(negedge clk);
    start = 0;
    while (done !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (done !== 1'b1) begin
      n_tests++; n_fail++;
      $display("FAIL %s R1: watchdog, got done=0 expected 1", tag);
    end else begin
      chk(busy, 0, {tag, " R1 busy low at done"});
    end
  endtask

  task automatic check_ids(input logic [N-1:0][IW-1:0] e, input logic [7:0] ok, input string tag);
    for (int k = 0; k < N; k++)
      chk(match_id[k*IW +: IW], e[k], $sformatf("%s id of op %0d", tag, k));
    chk(match_ok, ok, {tag, " match_ok"});
  endtask

  task automatic t_reset;
    logic [N-1:0][IW-1:0] e = '1;
    chk(busy, 0, "R9 busy");
    chk(done, 0, "R9 done");
    check_ids(e, 8'h00, "R9 reset");
  endtask

  task automatic t_chain;  // whole chain collapses
    logic [N-1:0][IW-1:0] e = '1;
    put(0, 0, 1,1,1, 1,1,2, 2, 0);
    put(1, 1, 1,0,0, 1,1,3, 1, 0);
    put(2, 0, 1,0,1, 1,1,1, 0, 1);
    run(3, "chain");
    e[0] = 0; e[1] = 0; e[2] = 0;
    check_ids(e, 8'h01, "R1 R7 chain");
    @(negedge clk);
    chk(done, 0, "R1 done one cycle");
  endtask

  task automatic t_illegal;  // memory op blocks its ancestry
    logic [N-1:0][IW-1:0] e = '1;
    put(0, 1, 1,1,1, 1,1,2, 0, 0);
    put(1, 4, 1,0,0, 0,0,0, 0, 0);
    put(2, 0, 1,0,1, 1,1,3, 0, 1);
    run(3, "illegal");
    check_ids(e, 8'h00, "R3 R7 illegal");
  endtask

  task automatic t_prio(input int s0, input int s1, input bit first_is_1, input string tag);
    logic [N-1:0][IW-1:0] e = '1;
    put(0, 1, 1,1,1, 1,1,2, s0, 1);
    put(1, 1, 1,1,3, 1,1,4, s1, 1);
    put(2, 0, 1,0,0, 1,0,1, 0, 1);
    run(3, tag);
    e[2] = 0;
    if (first_is_1) e[1] = 0; else e[0] = 0;
    check_ids(e, 8'h01, tag);
  endtask

  task automatic t_convex;
    logic [N-1:0][IW-1:0] e = '1;
    put(0, 0, 1,1,1, 1,1,2, 0, 0);
    put(1, 4, 1,0,0, 0,0,0, 3, 0);
    put(2, 0, 1,0,0, 1,0,1, 0, 1);
    run(3, "convex");
    check_ids(e, 8'h00, "R6 convex");
  endtask

  task automatic t_two;
    logic [N-1:0][IW-1:0] e = '1;
    put(0, 0, 1,1,1, 1,1,2, 1, 0);
    put(1, 1, 1,0,0, 1,1,3, 1, 1);
    put(2, 0, 1,1,4, 1,1,5, 1, 0);
    put(3, 1, 1,0,2, 1,1,6, 1, 1);
    put(4, 0, 1,0,1, 1,0,3, 0, 1);
    run(4, "two");
    e[2] = 0; e[3] = 0; e[0] = 1; e[1] = 1;
    check_ids(e, 8'h03, "R1 R7 R8 two chains");
  endtask

  task automatic t_inputs(input int r, input bit all4, input string tag);
    logic [N-1:0][IW-1:0] e = '1;
    put(0, 1, 1,1,1, 1,1,2, 2, 0);
    put(1, 1, 1,1,3, 1,1,4, 1, 0);
    put(2, 0, 1,0,0, 1,1,r, 0, 0);
    put(3, 0, 1,0,2, 1,0,1, 0, 1);
    run(4, tag);
    e[1] = 0; e[2] = 0; e[3] = 0;
    if (all4) e[0] = 0;
    check_ids(e, 8'h01, tag);
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_idx = '0; wr_cls = '0; wr_src_v = '0; wr_src_x = '0;
    wr_src_i = '0; wr_slack = '0; wr_live = 0; start = 0; n_ops = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_chain();
    t_illegal();
    t_prio(5, 0, 1, "R2 R5 lower slack op1");
    t_prio(0, 5, 0, "R2 R5 lower slack op0");
    t_prio(3, 3, 1, "R2 tie higher index");
    t_convex();
    t_two();
    t_inputs(5, 0, "R4 fifth input");
    t_inputs(1, 1, "R4 shared register");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule